// File: doc/BRIEF.md
# Register-Mapped Nonvolatile Byte Store Controller

This block sits on a CPU-side register bus and gives software byte-wide access to a nonvolatile array. The array is modelled as an internal memory. Each write takes a fixed number of cycles to commit. Software loads a two-part array address and a data byte, then drives the block through one control register. That register holds a read strobe, a write strobe, a short-lived write arm bit, an interrupt enable and a busy indication.

A write starts only through a two-step sequence. Software first sets the arm bit, then sets the write strobe while the arm window is still open. Once started, a write always runs to the end. It runs on even when a power-down sleep request arrives. The block keeps its oscillator request high and withholds sleep permission until the commit is done. A brown-out hold input blocks every register write and every write start while it is active. When a write finishes, a one-cycle ready pulse can be raised as an interrupt.

Top module: `nvm_reg_ctrl`

## Requirements
- R1: After reset, every register reads as zero, and `osc_req_o`, `slp_ok_o` and `rdy_irq_o` are low.
- R2: The array address is the high register's low ADDR_W-8 bits placed above the 8-bit low register. Register offsets are: 0 control, 1 address low, 2 address high, 3 data.
- R3: Writing control bit 0 as 1 while the block is idle starts a read. The addressed byte is loaded into the data register. Control bit 0 reads back as 1 for exactly one cycle, then clears.
- R4: A read strobe issued while a write is busy is ignored. The data register is not changed, and control bit 0 does not get set.
- R5: Writing control bit 2 opens an arm window of ARM_WIN cycles, after which bit 2 clears by itself. A write starts only if control bit 1 is written as 1 while the window is open.
- R6: A write keeps the block busy for exactly WR_CYCLES cycles. During that time control bit 1 reads as 1 and `osc_req_o` is high. At the end, the data byte is committed to the addressed location.
- R7: While a write is busy, bus writes to the address and data registers have no effect.
- R8: A sleep request does not stop a running write. `slp_ok_o` is high only when `slp_req_i` is high and no write is busy.
- R9: While `hold_i` is high, all bus register writes are ignored and no write can start.
- R10: When a write finishes, `rdy_irq_o` pulses high for one cycle, but only if control bit 3 (the interrupt enable) is set.
- R11: A bus read strobe in one cycle places the selected register's value on `bus_rdata_o` in the next cycle. The control register reads back as {4'b0, ie, arm, busy, rd}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | Brown-out hold; blocks writes and write starts |
| slp_req_i | input | 1 | Power-down sleep request |
| bus_addr_i | input | 2 | Register offset |
| bus_wdata_i | input | 8 | Bus write data |
| bus_we_i | input | 1 | Bus write strobe |
| bus_re_i | input | 1 | Bus read strobe |
| bus_rdata_o | output | 8 | Registered read data |
| osc_req_o | output | 1 | Oscillator request, high while a write is busy |
| slp_ok_o | output | 1 | Sleep permitted |
| rdy_irq_o | output | 1 | One-cycle write-complete pulse |

## Verification
The assertions take for granted that `hold_i` and `slp_req_i` are synchronous to `clk_i` and that the bus issues at most one strobe per cycle. They also assume `bus_addr_i` is stable while a strobe is high. The stimulus keeps to these assumptions. Every bus access is driven on the falling edge and held for exactly one cycle. The hold and sleep inputs are changed only on falling edges, between accesses.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_ALO  = 2'd1;
  localparam logic [1:0] REG_AHI  = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;
  localparam int CB_RD  = 0;
  localparam int CB_GO  = 1;
  localparam int CB_ARM = 2;
  localparam int CB_IE  = 3;
endpackage

// File: rtl/nvm_arm_win.sv
module nvm_arm_win #(
  parameter int WIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic armed_o
);
  localparam int CW = $clog2(WIN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (set_i)          cnt_q <= CW'(WIN);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign armed_o = (cnt_q != '0);
endmodule

// File: rtl/nvm_wr_timer.sv
module nvm_wr_timer #(
  parameter int CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= CW'(CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem_q [DEPTH];

  // nonvolatile model: no reset on the cells
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/nvm_reg_ctrl.sv
module nvm_reg_ctrl #(
  parameter int ADDR_W    = 10,
  parameter int WR_CYCLES = 64,
  parameter int ARM_WIN   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_i,
  input  logic       slp_req_i,
  input  logic [1:0] bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  input  logic       bus_we_i,
  input  logic       bus_re_i,
  output logic [7:0] bus_rdata_o,
  output logic       osc_req_o,
  output logic       slp_ok_o,
  output logic       rdy_irq_o
);
  import nvm_pkg::*;

  localparam int HW = ADDR_W - 8;

  logic [7:0]    addr_lo_q;
  logic [HW-1:0] addr_hi_q;
  logic [7:0]    data_q;
  logic          ie_q, rd_q, irq_q;
  logic [7:0]    rdata_q;
  logic          armed, busy, done;
  logic          wr_ok, ctrl_wr, start, arm_set, rd_ok;
  logic [ADDR_W-1:0] arr_addr;
  logic [7:0]    arr_rdata;

  assign wr_ok   = bus_we_i & ~hold_i;
  assign ctrl_wr = wr_ok & (bus_addr_i == REG_CTRL);
  assign arm_set = ctrl_wr & bus_wdata_i[CB_ARM];
  assign start   = ctrl_wr & bus_wdata_i[CB_GO] & armed & ~busy;
  assign rd_ok   = ctrl_wr & bus_wdata_i[CB_RD] & ~busy & ~start;
  assign arr_addr = {addr_hi_q, addr_lo_q};

  nvm_arm_win #(.WIN(ARM_WIN)) i_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(arm_set), .armed_o(armed)
  );

  nvm_wr_timer #(.CYC(WR_CYCLES)) i_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .busy_o(busy), .done_o(done)
  );

  nvm_array #(.AW(ADDR_W)) i_arr (
    .clk_i(clk_i), .we_i(done), .addr_i(arr_addr), .wdata_i(data_q), .rdata_o(arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      data_q    <= '0;
      ie_q      <= 1'b0;
      rd_q      <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      rd_q  <= rd_ok;
      irq_q <= done & ie_q;
      if (ctrl_wr) ie_q <= bus_wdata_i[CB_IE];
      if (wr_ok && !busy && bus_addr_i == REG_ALO) addr_lo_q <= bus_wdata_i;
      if (wr_ok && !busy && bus_addr_i == REG_AHI) addr_hi_q <= bus_wdata_i[HW-1:0];
      if (rd_ok) data_q <= arr_rdata;
      else if (wr_ok && !busy && bus_addr_i == REG_DATA) data_q <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (bus_re_i) begin
      unique case (bus_addr_i)
        REG_CTRL: rdata_q <= {4'b0, ie_q, armed, busy, rd_q};
        REG_ALO:  rdata_q <= addr_lo_q;
        REG_AHI:  rdata_q <= 8'(addr_hi_q);
        default:  rdata_q <= data_q;
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;
  assign osc_req_o   = busy;
  assign slp_ok_o    = slp_req_i & ~busy;
  assign rdy_irq_o   = irq_q;
endmodule

// File: rtl/nvm_reg_ctrl_chk.sv
module nvm_reg_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hold_i,
  input logic       bus_we_i,
  input logic [1:0] bus_addr_i,
  input logic       osc_req_o,
  input logic       rdy_irq_o,
  input logic       busy,
  input logic       done,
  input logic       rd_q,
  input logic [7:0] addr_lo_q
);
  // R9: no write start while held
  a_r9_hold_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !$rose(osc_req_o));

  // R6: a running write is never cut short
  a_r6_write_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done) |=> busy);

  // R10: ready pulse only at the end of a write
  a_r10_irq_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_irq_o |-> $fell(osc_req_o));

  // R4: no read while busy
  a_r4_no_read_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |-> !busy);

  // R7: address frozen while busy
  a_r7_addr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && bus_we_i && bus_addr_i == 2'd1) |=> $stable(addr_lo_q));
endmodule

bind nvm_reg_ctrl nvm_reg_ctrl_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .osc_req_o(osc_req_o), .rdy_irq_o(rdy_irq_o),
  .busy(busy), .done(done), .rd_q(rd_q), .addr_lo_q(addr_lo_q)
);

// File: tb/test_nvm_reg_ctrl.sv
module test_nvm_reg_ctrl;
  localparam int WR_CYCLES = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold = 1'b0, slp = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] rdata;
  logic       osc, slp_ok, irq;

  int checks = 0, fails = 0;
  bit finished = 0;
  byte unsigned exp_q[$];
  string tag_q[$];
  bit pend = 0;
  int run = 0, last_len = 0, irq_cnt = 0;

  always #10 clk = ~clk;

  nvm_reg_ctrl #(.ADDR_W(10), .WR_CYCLES(WR_CYCLES), .ARM_WIN(4)) i_nvm_reg_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .hold_i(hold), .slp_req_i(slp),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we), .bus_re_i(re),
    .bus_rdata_o(rdata), .osc_req_o(osc), .slp_ok_o(slp_ok), .rdy_irq_o(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input byte unsigned exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    re = 1'b1; addr = a;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (osc) @(negedge clk);
  endtask

  // monitor: scoreboard pop on the cycle after a read strobe
  always @(posedge clk) pend = re;
  always @(negedge clk) begin
    if (pend) begin
      string t;
      byte unsigned e;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rdata, e);
    end
    if (osc) run++;
    else if (run != 0) begin last_len = run; run = 0; end
    if (irq) irq_cnt++;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 osc", osc, 0);
    check("R1 slp_ok", slp_ok, 0);
    check("R1 irq", irq, 0);
    rd(2'd0, 8'h00, "R1 ctrl");
    rd(2'd1, 8'h00, "R1 alo");
    rd(2'd2, 8'h00, "R1 ahi");
    rd(2'd3, 8'h00, "R1 data");

    // write A5 at 0x134 with irq enabled
    wr(2'd1, 8'h34);
    wr(2'd2, 8'h01);
    wr(2'd3, 8'hA5);
    wr(2'd0, 8'h0C);
    wr(2'd0, 8'h0A);
    check("R6 osc busy", osc, 1);
    rd(2'd0, 8'h0E, "R11 R6 ctrl busy");
    rd(2'd2, 8'h01, "R2 ahi");
    // R7 / R4 during busy
    wr(2'd1, 8'h99);
    wr(2'd3, 8'h11);
    wr(2'd0, 8'h09);
    rd(2'd1, 8'h34, "R7 alo frozen");
    rd(2'd3, 8'hA5, "R4 R7 data kept");
    slp = 1'b1;
    @(negedge clk);
    check("R8 no sleep while busy", slp_ok, 0);
    check("R8 osc held", osc, 1);
    wait_idle();
    check("R8 sleep after write", slp_ok, 1);
    slp = 1'b0;
    idle(1);
    check("R6 busy length", last_len, WR_CYCLES);
    check("R10 one irq", irq_cnt, 1);

    // R3 read back
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h09);
    rd(2'd0, 8'h09, "R3 rd bit set");
    rd(2'd0, 8'h08, "R3 rd bit cleared");
    rd(2'd3, 8'hA5, "R3 data loaded");

    // second write, irq disabled, 0x5C at 0x034
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h5C);
    wr(2'd0, 8'h04);
    wr(2'd0, 8'h02);
    check("R6 second busy", osc, 1);
    wait_idle();
    idle(1);
    check("R10 no irq when disabled", irq_cnt, 1);

    // R2 both locations distinct
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h01);
    rd(2'd3, 8'hA5, "R2 hi location");
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    rd(2'd3, 8'h5C, "R2 lo location");

    // R5 strobe after window closes
    wr(2'd0, 8'h04);
    idle(4);
    wr(2'd0, 8'h02);
    check("R5 late strobe no start", osc, 0);
    rd(2'd0, 8'h00, "R5 arm self cleared");
    // R5 last cycle of window still starts
    wr(2'd0, 8'h04);
    idle(3);
    wr(2'd0, 8'h02);
    check("R5 last window cycle starts", osc, 1);
    wait_idle();

    // R9 hold blocks everything
    hold = 1'b1;
    wr(2'd3, 8'h77);
    wr(2'd0, 8'h04);
    wr(2'd0, 8'h02);
    check("R9 no start on hold", osc, 0);
    hold = 1'b0;
    rd(2'd3, 8'h5C, "R9 data untouched");
    rd(2'd0, 8'h00, "R9 arm not set");
    idle(2);
    check("R1 queue drained", exp_q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule